// File: doc/BRIEF.md
# Addressed Turnout Output Driver

This block is the decision logic on one output module of a shared, parallel turnout-command bus. The bus carries a 4-bit board address, a 3-bit output selector, a position bit and a strobe line. When the strobe rises and the board address equals the module's strapped identity, the block captures the selector and position. It then asserts exactly one of sixteen coil enables, two for each of eight turnouts, one per route direction. The enables steer an external capacitor-discharge pulse into the chosen coil.

Two release behaviours are available, selected by a static mode input. In level mode the enable follows the strobe and drops when the strobe falls. In feedback mode only the rising strobe matters. The enable is held until a digital copy of the discharge pulse has risen and fallen again. A watchdog count releases the coil if that copy never appears. The module remembers nothing between commands: once released, every enable is low and the captured command is cleared.

All bus inputs are taken to be synchronous to `clk`. The strobe edge is found by comparing the current strobe with its value at the previous clock edge.

Top module: `turnout_out_drv`

## Requirements
- R1: While reset is high, and in the cycle after it, every bit of `coil_en_o` is low.
- R2: A strobe rise is acted on only when `bus_board_i` equals `board_id_i`. A non-matching rise leaves every enable low.
- R3: The enable raised is bit index 2*`bus_sel_i` + `bus_pos_i`. A position of 1 (diverging route) gives the odd bit and a position of 0 (main route) gives the even bit.
- R4: Selector and position are captured at the clock edge that sees the strobe rise. Changes on them while the command is held do not alter the enable.
- R5: With `fb_mode_i` = 0, the enable is high from the cycle after the edge that sees the rise. It goes low in the cycle after the first edge that samples the strobe low.
- R6: With `fb_mode_i` = 1, a falling strobe has no effect. Once `pulse_fb_i` has been sampled high, the enable stays high until the cycle after the edge that samples `pulse_fb_i` low.
- R7: With `fb_mode_i` = 1, if `pulse_fb_i` is never high, the enable stays high for exactly `TIMEOUT_CYC` cycles. A feedback rise sampled on the final counted edge still wins and keeps the coil on.
- R8: At most one of the sixteen enables is high in any cycle.
- R9: A strobe rise while a command is held is ignored. This includes a rise sampled on the same edge that releases the held command.
- R10: No position is retained. After release all enables are low, and the next command raises only its own bit, whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_id_i | input | 4 | Strapped identity of this module |
| bus_board_i | input | 4 | Board address on the bus |
| bus_sel_i | input | 3 | Turnout selector on the bus |
| bus_pos_i | input | 1 | Route: 1 diverging, 0 main |
| strobe_i | input | 1 | Command strobe, acted on at its rise |
| fb_mode_i | input | 1 | 0 level release, 1 feedback release (static) |
| pulse_fb_i | input | 1 | Digital copy of the discharge pulse |
| coil_en_o | output | 16 | Coil enables, bit 2*sel+pos |

## Verification
Two functions can fall on the same edge: the release of a held command and the acceptance of a new strobe rise. The bench provokes this in feedback mode by dropping `pulse_fb_i` and raising the strobe with a different, matching command at the same instant. It judges that all enables go low and stay low, so the new command is lost rather than merged. A second collision sets the feedback rise on the very edge at which the timeout would expire. The bench expects the coil to stay on until the feedback falls.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int BOARD_W = 4;
    localparam int SEL_W   = 3;
    localparam int TURN_N  = 1 << SEL_W;
    localparam int COIL_N  = 2 * TURN_N;
    localparam int IDX_W   = SEL_W + 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             pos;
    } coil_cmd_t;

    typedef enum logic [1:0] {
        HOLD_IDLE  = 2'd0,
        HOLD_LEVEL = 2'd1,
        HOLD_WAIT  = 2'd2,
        HOLD_PULSE = 2'd3
    } hold_state_t;

    // Coil bit index: selector times two plus route bit.
    function automatic logic [IDX_W-1:0] coil_index(input coil_cmd_t c);
        return {c.sel, c.pos};
    endfunction

endpackage

// File: rtl/tod_strobe_front.sv
module tod_strobe_front
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe_i,
    input  logic [BOARD_W-1:0] board_i,
    input  logic [BOARD_W-1:0] id_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               pos_i,
    output logic               rise_o,
    output logic               hit_o,
    output coil_cmd_t          cmd_o
);

    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= strobe_i;
    end

    always_comb begin
        rise_o    = strobe_i & ~stb_q;
        hit_o     = (board_i == id_i);
        cmd_o.sel = sel_i;
        cmd_o.pos = pos_i;
    end

endmodule

// File: rtl/tod_hold_fsm.sv
module tod_hold_fsm
    import tod_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fb_mode_i,
    input  logic      take_i,
    input  logic      strobe_i,
    input  logic      fb_i,
    input  coil_cmd_t cmd_i,
    output logic      active_o,
    output logic      idle_o,
    output coil_cmd_t cmd_q_o
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    hold_state_t      state_q;
    coil_cmd_t        cmd_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HOLD_IDLE;
            cmd_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                HOLD_IDLE: begin
                    cnt_q <= '0;
                    if (take_i) begin
                        cmd_q   <= cmd_i;
                        state_q <= fb_mode_i ? HOLD_WAIT : HOLD_LEVEL;
                    end
                end
                HOLD_LEVEL: begin
                    if (!strobe_i) begin
                        state_q <= HOLD_IDLE;
                        cmd_q   <= '0;
                    end
                end
                HOLD_WAIT: begin
                    if (fb_i) begin
                        state_q <= HOLD_PULSE;
                    end else if (cnt_q == CNT_LAST) begin
                        state_q <= HOLD_IDLE;
                        cmd_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                HOLD_PULSE: begin
                    if (!fb_i) begin
                        state_q <= HOLD_IDLE;
                        cmd_q   <= '0;
                    end
                end
                default: state_q <= HOLD_IDLE;
            endcase
        end
    end

    assign active_o = (state_q != HOLD_IDLE);
    assign idle_o   = (state_q == HOLD_IDLE);
    assign cmd_q_o  = cmd_q;

endmodule

// File: rtl/tod_coil_decode.sv
module tod_coil_decode
    import tod_pkg::*;
(
    input  logic              active_i,
    input  coil_cmd_t         cmd_i,
    output logic [COIL_N-1:0] coil_en_o
);

    logic [IDX_W-1:0] idx;
    assign idx = coil_index(cmd_i);

    for (genvar g = 0; g < COIL_N; g++) begin : g_coil
        assign coil_en_o[g] = active_i && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/turnout_out_drv.sv
module turnout_out_drv
    import tod_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BOARD_W-1:0] board_id_i,
    input  logic [BOARD_W-1:0] bus_board_i,
    input  logic [SEL_W-1:0]   bus_sel_i,
    input  logic               bus_pos_i,
    input  logic               strobe_i,
    input  logic               fb_mode_i,
    input  logic               pulse_fb_i,
    output logic [COIL_N-1:0]  coil_en_o
);

    logic      stb_rise;
    logic      addr_hit;
    logic      fsm_idle;
    logic      fsm_active;
    coil_cmd_t bus_cmd;
    coil_cmd_t held_cmd;

    tod_strobe_front u_front (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .board_i  (bus_board_i),
        .id_i     (board_id_i),
        .sel_i    (bus_sel_i),
        .pos_i    (bus_pos_i),
        .rise_o   (stb_rise),
        .hit_o    (addr_hit),
        .cmd_o    (bus_cmd)
    );

    tod_hold_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .fb_mode_i (fb_mode_i),
        .take_i    (stb_rise & addr_hit),
        .strobe_i  (strobe_i),
        .fb_i      (pulse_fb_i),
        .cmd_i     (bus_cmd),
        .active_o  (fsm_active),
        .idle_o    (fsm_idle),
        .cmd_q_o   (held_cmd)
    );

    tod_coil_decode u_dec (
        .active_i  (fsm_active),
        .cmd_i     (held_cmd),
        .coil_en_o (coil_en_o)
    );

endmodule

// File: rtl/tod_checker.sv
module tod_checker
    import tod_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_i,
    input logic              fb_mode_i,
    input logic              pulse_fb_i,
    input logic              stb_rise,
    input logic              addr_hit,
    input logic              fsm_idle,
    input logic [COIL_N-1:0] coil_en_o
);

    logic [31:0] wait_cnt;
    logic        fb_seen;

    always_ff @(posedge clk) begin
        if (rst || coil_en_o == '0) begin
            wait_cnt <= '0;
            fb_seen  <= 1'b0;
        end else if (pulse_fb_i) begin
            fb_seen  <= 1'b1;
        end else if (fb_mode_i && !fb_seen) begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> coil_en_o == '0);

    // R2
    foreign_board_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_idle && stb_rise && !addr_hit) |=> coil_en_o == '0);

    // R5
    level_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!fb_mode_i && !strobe_i) |=> coil_en_o == '0);

    // R6
    feedback_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_mode_i && coil_en_o != '0 && pulse_fb_i) |=> coil_en_o == $past(coil_en_o));

    // R7
    timeout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= TIMEOUT_CYC);

    // R8
    single_coil_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(coil_en_o));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!fsm_idle && stb_rise) |=> (coil_en_o == '0 || coil_en_o == $past(coil_en_o)));

    // R10
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (coil_en_o != '0 && $past(coil_en_o) != '0) |-> coil_en_o == $past(coil_en_o));

endmodule

bind turnout_out_drv tod_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_i   (strobe_i),
    .fb_mode_i  (fb_mode_i),
    .pulse_fb_i (pulse_fb_i),
    .stb_rise   (stb_rise),
    .addr_hit   (addr_hit),
    .fsm_idle   (fsm_idle),
    .coil_en_o  (coil_en_o)
);

// File: tb/tb_turnout_out_drv.sv
module tb_turnout_out_drv;

    localparam int TO  = 6;
    localparam logic [3:0] MY_ID = 4'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  board_id = MY_ID;
    logic [3:0]  bus_board = '0;
    logic [2:0]  bus_sel = '0;
    logic        bus_pos = 1'b0;
    logic        strobe = 1'b0;
    logic        fb_mode = 1'b0;
    logic        pulse_fb = 1'b0;
    logic [15:0] coil_en;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    turnout_out_drv #(.TIMEOUT_CYC(TO)) dut (
        .clk         (clk),
        .rst         (rst),
        .board_id_i  (board_id),
        .bus_board_i (bus_board),
        .bus_sel_i   (bus_sel),
        .bus_pos_i   (bus_pos),
        .strobe_i    (strobe),
        .fb_mode_i   (fb_mode),
        .pulse_fb_i  (pulse_fb),
        .coil_en_o   (coil_en)
    );

    function automatic logic [15:0] expect_bit(input logic [2:0] s, input logic p);
        return 16'd1 << (2 * int'(s) + int'(p));
    endfunction

    task automatic tk();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        n_chk++;
        if (coil_en !== exp) begin
            n_bad++;
            $display("FAIL %s: coil_en=%h expected=%h at %0t", req, coil_en, exp, $time);
        end
    endtask

    task automatic drive(input logic [3:0] b, input logic [2:0] s, input logic p);
        bus_board = b; bus_sel = s; bus_pos = p; strobe = 1'b1;
    endtask

    // Level-mode transaction with a mid-hold bus change.
    task automatic level_txn(input logic [3:0] b, input logic [2:0] s, input logic p);
        logic [15:0] e;
        e = (b == MY_ID) ? expect_bit(s, p) : 16'h0;
        tk(); drive(b, s, p);
        tk(); check("R2/R3", e);
        bus_sel = s ^ 3'd3; bus_pos = ~p; bus_board = MY_ID;
        tk(); check("R4", e);
        strobe = 1'b0;
        tk(); check("R5", 16'h0);
    endtask

    // Feedback-mode transaction: strobe falls early, pulse lasts two cycles.
    task automatic fb_txn(input logic [3:0] b, input logic [2:0] s, input logic p);
        logic [15:0] e;
        e = (b == MY_ID) ? expect_bit(s, p) : 16'h0;
        tk(); drive(b, s, p);
        tk(); check("R2/R3", e);
        strobe = 1'b0;
        tk(); check("R6", e);
        pulse_fb = 1'b1;
        tk(); check("R6", e);
        tk(); check("R6", e);
        pulse_fb = 1'b0;
        tk(); check("R6/R10", 16'h0);
    endtask

    task automatic run_all();
        repeat (3) begin tk(); check("R1", 16'h0); end
        rst = 1'b0;
        tk(); check("R1", 16'h0);

        // Level mode: every board address, every coil for the own address.
        for (int b = 0; b < 16; b++)
            for (int s = 0; s < 8; s++)
                for (int p = 0; p < 2; p++)
                    if (b == int'(MY_ID) || (s == 0 && p == 0))
                        level_txn(4'(b), 3'(s), 1'(p));
        for (int b = 0; b < 16; b++)
            if (b != int'(MY_ID)) level_txn(4'(b), 3'(b), 1'(b));

        // Feedback mode.
        fb_mode = 1'b1;
        for (int s = 0; s < 8; s++)
            for (int p = 0; p < 2; p++)
                fb_txn(MY_ID, 3'(s), 1'(p));
        fb_txn(4'd9, 3'd2, 1'b1);

        // R7: no feedback ever, exact timeout length.
        tk(); drive(MY_ID, 3'd7, 1'b1);
        tk(); check("R7", expect_bit(3'd7, 1'b1));
        strobe = 1'b0;
        for (int i = 1; i < TO; i++) begin tk(); check("R7", expect_bit(3'd7, 1'b1)); end
        tk(); check("R7", 16'h0);

        // R7: feedback rising on the last counted edge wins.
        tk(); drive(MY_ID, 3'd1, 1'b0);
        tk(); check("R7", expect_bit(3'd1, 1'b0));
        strobe = 1'b0;
        for (int i = 1; i < TO; i++) begin tk(); check("R7", expect_bit(3'd1, 1'b0)); end
        pulse_fb = 1'b1;
        tk(); check("R7", expect_bit(3'd1, 1'b0));
        pulse_fb = 1'b0;
        tk(); check("R7", 16'h0);

        // R9: new rise while waiting for feedback is ignored.
        tk(); drive(MY_ID, 3'd4, 1'b0);
        tk(); check("R9", expect_bit(3'd4, 1'b0));
        strobe = 1'b0;
        tk(); check("R9", expect_bit(3'd4, 1'b0));
        drive(MY_ID, 3'd6, 1'b1);
        tk(); check("R9", expect_bit(3'd4, 1'b0));
        strobe = 1'b0; pulse_fb = 1'b1;
        tk(); check("R9", expect_bit(3'd4, 1'b0));
        // R9: rise on the releasing edge is lost.
        pulse_fb = 1'b0; drive(MY_ID, 3'd2, 1'b1);
        tk(); check("R9", 16'h0);
        tk(); check("R9", 16'h0);
        strobe = 1'b0;
        tk(); check("R9", 16'h0);

        // R10: a later command raises only its own bit.
        fb_txn(MY_ID, 3'd0, 1'b1);

        // R1: reset mid-hold clears everything.
        fb_mode = 1'b0;
        tk(); drive(MY_ID, 3'd3, 1'b1);
        tk(); check("R5", expect_bit(3'd3, 1'b1));
        rst = 1'b1;
        tk(); check("R1", 16'h0);
        strobe = 1'b0; rst = 1'b0;
        tk(); check("R1", 16'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule